// File: doc/BRIEF.md
# Protected Memory Write-Access Controller

This block guards a small on-chip user memory divided into equal areas. Every area carries its own set of four protection flags, and the block decides for each read, write or flag-setting request from a serial-slave front end whether it is carried out. The memory itself is a register array inside the block. The last area holds the device secret, which external reads can never return.

Writes to an area marked for authentication are not committed straight away. The block asks an external MAC engine for the expected 256-bit MAC and supplies the new word, the word now stored at the target address and the secret. It then waits for the engine's done strobe and compares the returned value with the MAC the host sent alongside the write. Data is stored only on an exact match. Write protection overrides everything, including a correct MAC. The emulation flag turns any commit into a bit-clearing AND of the old and new values.

Every accepted request produces one response with a two-bit status code. The hash function, the bus protocol and the nonvolatile cell physics sit outside this block.

Top module: `prot_mem_guard`

## Requirements
- R1: After reset, every flag of every area is clear, every memory word is zero, `busy`, `rsp_valid` and `mac_req` are low, and a read of an ordinary area returns zero with status 00.
- R2: `req_op` selects the operation: 00 is a read, 01 is a write and 1x sets flags. A request is accepted when `req_valid` is high and `busy` is low. An unprotected read returns the stored word with status 00, and an unprotected write stores `req_wdata` with status 00.
- R3: Flag bits are bit 0 read lock, bit 1 write lock, bit 2 emulation and bit 3 authentication. A set request ORs `req_wdata[3:0]` into the flags of the area addressed by the upper bits of `req_addr`, and flags are never cleared until reset. Flags combine: each set flag applies its own restriction.
- R4: A read of an area whose read-lock flag is set returns status 11 and data zero.
- R5: A read of the secret area (the highest area index) always returns status 11 and data zero, whatever its flags, while its contents still reach `mac_secret`.
- R6: A write to an area whose write-lock flag is set returns status 01, leaves memory unchanged and raises no MAC request, even when the authentication flag is also set and the MAC is correct.
- R7: With the emulation flag set, a committed write stores the old word ANDed with the new word, so no bit can go from 0 to 1.
- R8: With the authentication flag set, a write raises `mac_req` and presents the new word, the current word and the secret. It then holds until `mac_done`, and commits with status 00 only if `mac_value` equals `req_mac` in all 256 bits.
- R9: When any bit of the host MAC differs from the engine's value, the write returns status 10 and memory is unchanged.
- R10: While waiting for the MAC engine, `busy` and `mac_req` stay high, and new requests are ignored: they produce no response and no effect.
- R11: The response (`rsp_valid` high for one cycle with status and data) appears on the clock edge that completes the request. For most requests this is the accepting edge; for an authenticated write it is the edge that samples `mac_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 write, 1x set flags |
| req_addr | input | ADDR_W (4) | Word address; upper bits select the area |
| req_wdata | input | DATA_W (32) | Write data, or flag bits in [3:0] |
| req_mac | input | MAC_W (256) | Host-supplied MAC for authenticated writes |
| busy | output | 1 | Waiting for the MAC engine |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 00 ok, 01 write locked, 10 MAC mismatch, 11 read denied |
| rsp_rdata | output | DATA_W (32) | Read data, zero unless a read succeeded |
| mac_req | output | 1 | Request to the MAC engine |
| mac_new_data | output | DATA_W (32) | Word the host wants to write |
| mac_old_data | output | DATA_W (32) | Word currently stored at the target |
| mac_secret | output | SEC_W (128) | Secret area contents, lowest word in the low bits |
| mac_done | input | 1 | MAC engine result strobe |
| mac_value | input | MAC_W (256) | MAC computed by the engine |

## Verification
The hardest cases to reach from the ports are the ones inside the wait for the MAC engine. A request arriving while the block is busy must vanish without a trace. A MAC that differs from the engine's result in a single high bit must leave the stored word untouched. The bench plays the MAC engine with a fixed delay of several cycles. During that window it injects a read that would produce an unexpected response if accepted. It also sends one write whose host MAC has a single bit flipped, then reads the word back. Protections are stacked on the same areas in sequence: authentication with write lock, and authentication with emulation. This shows which restriction wins on a single write.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_WLOCK  = 2'b01,
    ST_BADMAC = 2'b10,
    ST_RDENY  = 2'b11
  } status_e;

  typedef enum logic [0:0] {
    FSM_IDLE = 1'b0,
    FSM_WAIT = 1'b1
  } fsm_e;

  // packed: the last field is bit 0
  typedef struct packed {
    logic auth;     // bit 3
    logic emul;     // bit 2
    logic wr_lock;  // bit 1
    logic rd_lock;  // bit 0
  } prot_t;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/pmg_flag_bank.sv
module pmg_flag_bank
  import pmg_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [AREA_W-1:0]           set_area,
  input  prot_t                       set_bits,
  output prot_t [NUM_AREAS-1:0]       flags_o
);

  prot_t [NUM_AREAS-1:0] flags_q;
  prot_t [NUM_AREAS-1:0] flags_d;

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    logic hit;
    assign hit = set_en && (set_area == AREA_W'(g));

    always_comb begin
      flags_d[g] = flags_q[g];
      if (hit) flags_d[g] = flags_q[g] | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= '0;
      else        flags_q[g] <= flags_d[g];
    end
  end

  assign flags_o = flags_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~flags_q) == '0)); // R3

endmodule

// File: rtl/pmg_store.sv
module pmg_store #(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 32,
  parameter int SEC_BASE  = 12,
  parameter int SEC_WORDS = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SEC_W  = SEC_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEC_W-1:0]  secret_o
);

  logic [DEPTH-1:0][DATA_W-1:0] word_q;
  logic [DEPTH-1:0][DATA_W-1:0] word_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic wen;
    assign wen = we && (addr == ADDR_W'(i));

    always_comb begin
      word_d[i] = word_q[i];
      if (wen) word_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= '0;
      else        word_q[i] <= word_d[i];
    end
  end

  for (genvar s = 0; s < SEC_WORDS; s++) begin : g_sec
    assign secret_o[s*DATA_W +: DATA_W] = word_q[SEC_BASE + s];
  end

  assign rdata = word_q[addr];

endmodule

// File: rtl/pmg_mac_cmp.sv
module pmg_mac_cmp #(
  parameter int MAC_W = 256,
  parameter int CHUNK = 32,
  localparam int NCH  = MAC_W / CHUNK
) (
  input  logic [MAC_W-1:0] host_mac,
  input  logic [MAC_W-1:0] calc_mac,
  output logic             match
);

  logic [NCH-1:0] chunk_eq;

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    assign chunk_eq[c] = (host_mac[c*CHUNK +: CHUNK] == calc_mac[c*CHUNK +: CHUNK]);
  end

  assign match = &chunk_eq;

  initial begin
    AST_CHUNK_FIT: assert (NCH * CHUNK == MAC_W); // R9
  end

endmodule

// File: rtl/prot_mem_guard.sv
module prot_mem_guard
  import pmg_pkg::*;
#(
  parameter int NUM_AREAS      = 4,
  parameter int WORDS_PER_AREA = 4,
  parameter int DATA_W         = 32,
  parameter int MAC_W          = 256,
  parameter int CMP_CHUNK      = 32,
  localparam int WORD_W = (WORDS_PER_AREA > 1) ? $clog2(WORDS_PER_AREA) : 1,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int ADDR_W = AREA_W + WORD_W,
  localparam int SEC_W  = WORDS_PER_AREA * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MAC_W-1:0]  req_mac,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mac_req,
  output logic [DATA_W-1:0] mac_new_data,
  output logic [DATA_W-1:0] mac_old_data,
  output logic [SEC_W-1:0]  mac_secret,
  input  logic              mac_done,
  input  logic [MAC_W-1:0]  mac_value
);

  localparam int DEPTH       = 1 << ADDR_W;
  localparam int SECRET_AREA = NUM_AREAS - 1;
  localparam int SEC_BASE    = SECRET_AREA * WORDS_PER_AREA;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // state
  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [MAC_W-1:0]  pend_mac_q;
  logic              rsp_valid_q, rsp_valid_d;
  status_e           rsp_status_q, rsp_status_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  // datapath
  logic                  accept, load_pend;
  logic [ADDR_W-1:0]     cur_addr;
  logic [AREA_W-1:0]     cur_area;
  logic [DATA_W-1:0]     new_data, old_data, commit_data;
  prot_t [NUM_AREAS-1:0] flags;
  prot_t                 cur_flags;
  logic                  mem_we, set_en, mac_match;

  assign accept    = req_valid && (state_q == FSM_IDLE);
  assign cur_addr  = (state_q == FSM_WAIT) ? pend_addr_q : req_addr;
  assign cur_area  = cur_addr[ADDR_W-1:WORD_W];
  assign new_data  = (state_q == FSM_WAIT) ? pend_data_q : req_wdata;
  assign cur_flags = flags[cur_area];
  assign commit_data = cur_flags.emul ? (old_data & new_data) : new_data;

  pmg_flag_bank #(.NUM_AREAS(NUM_AREAS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (set_en),
    .set_area (req_addr[ADDR_W-1:WORD_W]),
    .set_bits (prot_t'(req_wdata[3:0])),
    .flags_o  (flags)
  );

  pmg_store #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .SEC_BASE  (SEC_BASE),
    .SEC_WORDS (WORDS_PER_AREA)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (mem_we),
    .addr     (cur_addr),
    .wdata    (commit_data),
    .rdata    (old_data),
    .secret_o (mac_secret)
  );

  pmg_mac_cmp #(.MAC_W(MAC_W), .CHUNK(CMP_CHUNK)) u_cmp (
    .host_mac (pend_mac_q),
    .calc_mac (mac_value),
    .match    (mac_match)
  );

  // next-state decision
  always_comb begin
    state_d      = state_q;
    rsp_valid_d  = 1'b0;
    rsp_status_d = ST_OK;
    rsp_rdata_d  = '0;
    mem_we       = 1'b0;
    set_en       = 1'b0;
    load_pend    = 1'b0;
    if (state_q == FSM_IDLE) begin
      if (accept) begin
        if (req_op == OP_READ) begin
          rsp_valid_d = 1'b1;
          if (cur_flags.rd_lock || (cur_area == AREA_W'(SECRET_AREA))) rsp_status_d = ST_RDENY;
          else rsp_rdata_d = old_data;
        end else if (req_op == OP_WRITE) begin
          if (cur_flags.wr_lock) begin
            rsp_valid_d  = 1'b1;
            rsp_status_d = ST_WLOCK;
          end else if (cur_flags.auth) begin
            load_pend = 1'b1;
            state_d   = FSM_WAIT;
          end else begin
            rsp_valid_d = 1'b1;
            mem_we      = 1'b1;
          end
        end else begin
          rsp_valid_d = 1'b1;
          set_en      = 1'b1;
        end
      end
    end else if (mac_done) begin
      rsp_valid_d = 1'b1;
      state_d     = FSM_IDLE;
      if (mac_match) mem_we = 1'b1;
      else rsp_status_d = ST_BADMAC;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= FSM_IDLE;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
      rsp_rdata_q  <= '0;
    end else begin
      state_q      <= state_d;
      rsp_valid_q  <= rsp_valid_d;
      rsp_status_q <= rsp_status_d;
      rsp_rdata_q  <= rsp_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_mac_q  <= '0;
    end else if (load_pend) begin
      pend_addr_q <= req_addr;
      pend_data_q <= req_wdata;
      pend_mac_q  <= req_mac;
    end
  end

  assign busy         = (state_q == FSM_WAIT);
  assign mac_req      = (state_q == FSM_WAIT);
  assign mac_new_data = pend_data_q;
  assign mac_old_data = old_data;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_status   = rsp_status_q;
  assign rsp_rdata    = rsp_rdata_q;

  // checks
  AST_WLOCK_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> !flags[cur_area].wr_lock); // R6
  AST_EMUL_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && flags[cur_area].emul) |-> ((commit_data & ~old_data) == '0)); // R7
  AST_AUTH_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && flags[cur_area].auth) |-> (mac_done && (pend_mac_q == mac_value))); // R8
  AST_DENY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_q && (rsp_status_q == ST_RDENY)) |-> (rsp_rdata_q == '0)); // R4
  AST_MACREQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mac_req && !mac_done) |=> mac_req); // R10
  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !mac_done) |=> ($stable(pend_addr_q) && $stable(pend_mac_q) && !rsp_valid_q)); // R10
  AST_DONE_RESPONDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && mac_done) |=> (rsp_valid_q && !busy)); // R11

endmodule

// File: tb/tb_prot_mem_guard.sv
module tb_prot_mem_guard;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int MAC_W  = 256;
  localparam int SEC_W  = 128;

  typedef struct {
    logic [1:0]        status;
    logic [DATA_W-1:0] rdata;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [MAC_W-1:0]  req_mac = '0;
  logic              busy, rsp_valid, mac_req;
  logic [1:0]        rsp_status;
  logic [DATA_W-1:0] rsp_rdata, mac_new_data, mac_old_data;
  logic [SEC_W-1:0]  mac_secret;
  logic              mac_done = 1'b0;
  logic [MAC_W-1:0]  mac_value = '0;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t exp_q[$];
  logic [DATA_W-1:0] mem_m [16];
  logic [3:0]        flg_m [4];

  always #10 clk = ~clk;

  prot_mem_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mac(req_mac),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .mac_req(mac_req), .mac_new_data(mac_new_data),
    .mac_old_data(mac_old_data), .mac_secret(mac_secret),
    .mac_done(mac_done), .mac_value(mac_value)
  );

  function automatic logic [MAC_W-1:0] mac_f(logic [DATA_W-1:0] nw, logic [DATA_W-1:0] old,
                                             logic [SEC_W-1:0] sec);
    return {nw, old, sec, ~nw, nw ^ old};
  endfunction

  function automatic logic [SEC_W-1:0] secret_m();
    return {mem_m[15], mem_m[14], mem_m[13], mem_m[12]};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", 64'(rsp_status), 64'hff);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_status == e.status, {e.tag, " status"}, 64'(rsp_status), 64'(e.status));
          check(rsp_rdata == e.rdata, {e.tag, " data"}, 64'(rsp_rdata), 64'(e.rdata));
        end
      end
    end
  end

  // MAC engine model
  initial begin
    forever begin
      @(negedge clk);
      if (mac_req && !mac_done) begin
        repeat (4) @(negedge clk);
        mac_value = mac_f(mac_new_data, mac_old_data, mac_secret);
        mac_done  = 1'b1;
        @(negedge clk);
        mac_done  = 1'b0;
      end
    end
  end

  // driver: computes expectation from the model, pushes it, drives the request
  task automatic do_req(logic [1:0] op, int addr, logic [DATA_W-1:0] wd, bit good_mac,
                        bit poke, string tag);
    exp_t e;
    int area;
    logic [3:0] f;
    logic [MAC_W-1:0] hm;
    bit waits;
    area = addr / 4;
    f = flg_m[area];
    hm = mac_f(wd, mem_m[addr], secret_m());
    if (!good_mac) hm[200] = ~hm[200];
    e.tag = tag; e.status = 2'b00; e.rdata = '0; waits = 1'b0;
    if (op == 2'b00) begin
      if (f[0] || area == 3) e.status = 2'b11;
      else e.rdata = mem_m[addr];
    end else if (op == 2'b01) begin
      if (f[1]) e.status = 2'b01;
      else if (f[3] && !good_mac) begin e.status = 2'b10; waits = 1'b1; end
      else begin
        waits = f[3];
        mem_m[addr] = f[2] ? (mem_m[addr] & wd) : wd;
      end
    end else begin
      flg_m[area] = flg_m[area] | wd[3:0];
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = ADDR_W'(addr); req_wdata = wd; req_mac = hm;
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 2'b01 && f[3] && !f[1]) begin
      check(busy && mac_req, {tag, " R10 busy while waiting"}, 64'({busy, mac_req}), 64'h3);
      if (poke) begin
        req_valid = 1'b1; req_op = 2'b00; req_addr = '0;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end else if (op == 2'b01 && f[1]) begin
      check(!mac_req && !busy, {tag, " R6 no MAC request"}, 64'(mac_req), 64'h0);
    end
    if (waits) while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    for (int i = 0; i < 4; i++) flg_m[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !rsp_valid && !mac_req, "R1 outputs in reset", 64'({busy, rsp_valid, mac_req}), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !rsp_valid && !mac_req, "R1 outputs after reset", 64'({busy, rsp_valid, mac_req}), 64'h0);
    do_req(2'b00, 5, '0, 1, 0, "R1 read zero");
    do_req(2'b01, 1, 32'hA5A5_0F0F, 1, 0, "R2 plain write");
    do_req(2'b00, 1, '0, 1, 0, "R2 read back");
    do_req(2'b00, 0, '0, 1, 0, "R11 back-to-back read");
    // install secret
    for (int w = 12; w < 16; w++) do_req(2'b01, w, 32'h5EC0_0000 + w, 1, 0, "R2 secret install");
    do_req(2'b00, 13, '0, 1, 0, "R5 secret read denied");
    // read lock on area 1
    do_req(2'b01, 4, 32'h1111_2222, 1, 0, "R2 area1 write");
    do_req(2'b10, 4, 32'h1, 1, 0, "R3 set read lock");
    do_req(2'b00, 4, '0, 1, 0, "R4 read locked");
    do_req(2'b10, 4, 32'h0, 1, 0, "R3 set nothing");
    do_req(2'b00, 4, '0, 1, 0, "R3 lock sticky");
    do_req(2'b10, 4, 32'h2, 1, 0, "R3 add write lock");
    do_req(2'b01, 5, 32'hFFFF_FFFF, 1, 0, "R6 write locked area1");
    // emulation on area 2
    do_req(2'b01, 8, 32'hF0F0_FFFF, 1, 0, "R2 area2 write");
    do_req(2'b10, 8, 32'h4, 1, 0, "R3 set emulation");
    do_req(2'b01, 8, 32'h0FF0_00FF, 1, 0, "R7 emul write");
    do_req(2'b00, 8, '0, 1, 0, "R7 emul and result");
    do_req(2'b01, 8, 32'hFFFF_FFFF, 1, 0, "R7 emul no set bits");
    do_req(2'b00, 8, '0, 1, 0, "R7 emul unchanged");
    // authentication on area 0
    do_req(2'b10, 0, 32'h8, 1, 0, "R3 set auth");
    do_req(2'b01, 2, 32'h1234_5678, 1, 1, "R8 auth good mac");
    do_req(2'b00, 2, '0, 1, 0, "R8 auth committed");
    do_req(2'b01, 2, 32'hDEAD_BEEF, 0, 1, "R9 auth bad mac");
    do_req(2'b00, 2, '0, 1, 0, "R9 memory unchanged");
    do_req(2'b00, 0, '0, 1, 0, "R10 poke had no effect");
    // auth plus emulation on area 2
    do_req(2'b10, 9, 32'h8, 1, 0, "R3 add auth to emul");
    do_req(2'b01, 8, 32'h00F0_000F, 1, 0, "R7 R8 auth emul write");
    do_req(2'b00, 8, '0, 1, 0, "R7 R8 auth emul result");
    // write lock overrides auth on area 0
    do_req(2'b10, 0, 32'h2, 1, 0, "R3 add write lock to auth");
    do_req(2'b01, 2, 32'h0BAD_F00D, 1, 0, "R6 lock beats good mac");
    do_req(2'b00, 2, '0, 1, 0, "R6 memory unchanged");
    do_req(2'b10, 12, 32'h0, 1, 0, "R5 secret flags clear");
    do_req(2'b00, 12, '0, 1, 0, "R5 secret still denied");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all responses seen", 64'(exp_q.size()), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R11 watchdog expired", 64'h0, 64'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule